// File: doc/BRIEF.md
# Streaming Discrete-Time Cellular Network Processor

This block applies one update step of a cellular nonlinear network to an image that arrives as a raster-ordered pixel stream. For every cell it receives two values: the cell's input pixel and the cell's initial state. Each cell's new state is the sum of three parts. The first is a 3x3 feedback template weighted over the neighbours' outputs. The second is a 3x3 control template weighted over the neighbours' inputs. The third is a constant bias. A neighbour's output is its initial state passed through a unit clamp. The new state comes out together with its clamped output, so an outer loop can send the state stream back in to run further iterations. Influence reaches cells further away only through those repeated passes.

The same nineteen coefficients apply at every cell. Software writes them through a small register port into a pending bank. That bank becomes active only when the first pixel of a new frame is accepted, so a frame in progress always sees one consistent set. All values are 16-bit signed with 12 fractional bits (1.0 = 4096). Positions beyond the frame edge count as zero. After the last pixel, the block drains its own window pipeline without further input.

Top module: `dtcnn_stream`

## Requirements
- R1: The new state of a cell is the full-precision sum of the feedback products, the control products and bias*4096, arithmetically shifted right by 12 (rounding towards minus infinity) and then saturated to [-32768, 32767].
- R2: The output of a result is its new state clamped to [-4096, 4096]. The neighbour outputs used by the feedback template are the initial states clamped to the same range.
- R3: Coefficient k is applied to the neighbour at row offset k/3-1 and column offset k%3-1 (row -1 is the line above, column -1 the pixel to the left). The same coefficients are used for every cell.
- R4: A neighbour position outside the frame contributes zero for both its input and its output.
- R5: Register addresses 0..8 hold feedback coefficients 0..8, addresses 9..17 hold control coefficients 0..8, and address 18 holds the bias. A write goes to a pending bank. The pending bank is copied to the active bank when a pixel with the frame-start flag is accepted. Writes made during a frame do not change that frame's results.
- R6: Exactly COLS*ROWS results are produced per frame, in raster order. The result for pixel p appears, with out_valid high, after the clock edge that follows acceptance of pixel p+COLS+1. For the last COLS+1 pixels, the block feeds itself during the COLS+1 cycles after the last pixel.
- R7: A pixel presented without the frame-start flag is dropped when no frame is open (after reset, or once COLS*ROWS pixels of the frame have been accepted). Such a pixel produces no result.
- R8: After reset, out_valid, out_state and out_y are 0, and both coefficient banks hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pixel is present this cycle |
| in_sof | input | 1 | The present pixel is the first of a frame |
| in_u | input | 16 | Cell input value, Q4.12 |
| in_x | input | 16 | Cell initial state, Q4.12 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Coefficient address (0..18) |
| cfg_wdata | input | 16 | Coefficient value, Q4.12 |
| out_valid | output | 1 | A result is present |
| out_state | output | 16 | New cell state, Q4.12 |
| out_y | output | 16 | Clamped cell output, Q4.12 |

## Verification
The bench builds the block with COLS=5 and ROWS=4. On a 20-cell frame most windows cross at least one edge, so border zeroing is exercised on nearly every result, and the self-drain after the last pixel takes only six cycles. At this size the bench can sweep each of the eighteen coefficient positions on its own and compare every result of every frame against an arithmetic model of the update. Saturation extremes, the pending-to-active bank switch and dropped stray pixels each get dedicated frames.

// File: rtl/dtcnn_pkg.sv
package dtcnn_pkg;
    localparam int DW     = 16;
    localparam int FW     = 12;
    localparam int TAPS   = 9;
    localparam int ADDR_W = 5;
    localparam int ACC_W  = 2 * DW + $clog2(2 * TAPS + 1) + 1;
    localparam int ONE    = 1 << FW;
    localparam int WMAX   = (1 << (DW - 1)) - 1;
    localparam int WMIN   = -(1 << (DW - 1));

    typedef logic signed [DW-1:0]    word_t;
    typedef word_t [TAPS-1:0]        tap_vec_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    function automatic word_t sat_acc(input acc_t v);
        if (v > acc_t'(WMAX))      return word_t'(WMAX);
        else if (v < acc_t'(WMIN)) return word_t'(WMIN);
        else                       return v[DW-1:0];
    endfunction

    function automatic word_t clamp_unit(input word_t v);
        if (v > word_t'(ONE))       return word_t'(ONE);
        else if (v < -word_t'(ONE)) return -word_t'(ONE);
        else                        return v;
    endfunction
endpackage

// File: rtl/dtcnn_coef_bank.sv
module dtcnn_coef_bank
    import dtcnn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  word_t             cfg_wdata,
    input  logic              swap,
    output tap_vec_t          fb_coef,
    output tap_vec_t          ct_coef,
    output word_t             bias
);
    typedef struct packed {
        tap_vec_t pend_fb;
        tap_vec_t pend_ct;
        word_t    pend_bias;
        tap_vec_t act_fb;
        tap_vec_t act_ct;
        word_t    act_bias;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swap) begin
            st_d.act_fb   = st_q.pend_fb;
            st_d.act_ct   = st_q.pend_ct;
            st_d.act_bias = st_q.pend_bias;
        end
        if (cfg_we) begin
            for (int k = 0; k < TAPS; k++) begin
                if (cfg_addr == ADDR_W'(k))        st_d.pend_fb[k] = cfg_wdata;
                if (cfg_addr == ADDR_W'(TAPS + k)) st_d.pend_ct[k] = cfg_wdata;
            end
            if (cfg_addr == ADDR_W'(2 * TAPS)) st_d.pend_bias = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_coef = st_q.act_fb;
    assign ct_coef = st_q.act_ct;
    assign bias    = st_q.act_bias;

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(st_q.act_fb) && $stable(st_q.act_ct) && $stable(st_q.act_bias));
endmodule

// File: rtl/dtcnn_window.sv
module dtcnn_window
    import dtcnn_pkg::*;
#(
    parameter int COLS = 32,
    parameter int ROWS = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_sof,
    input  word_t    in_u,
    input  word_t    in_x,
    output logic     frame_go,
    output logic     win_valid,
    output tap_vec_t win_u,
    output tap_vec_t win_y
);
    localparam int NPIX  = COLS * ROWS;
    localparam int DEPTH = 2 * COLS + 3;
    localparam int TOTAL = NPIX + COLS + 1;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam int COL_W = $clog2(COLS + 1);
    localparam int ROW_W = $clog2(ROWS + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] su;
        logic [DEPTH-1:0][DW-1:0] sy;
        logic [CNT_W-1:0]         cnt;
        logic [COL_W-1:0]         nxt_col;
        logic [ROW_W-1:0]         nxt_row;
        logic [COL_W-1:0]         win_col;
        logic [ROW_W-1:0]         win_row;
        logic                     win_valid;
    } win_t;

    win_t st_d, st_q;
    logic accept, flushing, step;
    logic [CNT_W-1:0] n_idx;

    always_comb begin
        st_d     = st_q;
        accept   = in_valid && (in_sof || (st_q.cnt < CNT_W'(NPIX)));
        flushing = (st_q.cnt >= CNT_W'(NPIX)) && (st_q.cnt < CNT_W'(TOTAL));
        step     = accept || flushing;
        n_idx    = (accept && in_sof) ? '0 : st_q.cnt;
        st_d.win_valid = 1'b0;
        if (step) begin
            if (accept && in_sof) begin
                st_d.su      = '0;
                st_d.sy      = '0;
                st_d.nxt_col = '0;
                st_d.nxt_row = '0;
            end else begin
                st_d.su = st_q.su << DW;
                st_d.sy = st_q.sy << DW;
            end
            st_d.su[0] = accept ? in_u : '0;
            st_d.sy[0] = accept ? clamp_unit(in_x) : '0;
            st_d.cnt   = n_idx + CNT_W'(1);
            if (n_idx >= CNT_W'(COLS + 1)) begin
                st_d.win_valid = 1'b1;
                st_d.win_col   = st_q.nxt_col;
                st_d.win_row   = st_q.nxt_row;
                if (st_q.nxt_col == COL_W'(COLS - 1)) begin
                    st_d.nxt_col = '0;
                    st_d.nxt_row = st_q.nxt_row + ROW_W'(1);
                end else begin
                    st_d.nxt_col = st_q.nxt_col + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_W'(TOTAL);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam int DR = k / 3 - 1;
        localparam int DC = k % 3 - 1;
        localparam int J  = COLS + 1 - DR * COLS - DC;
        logic in_frame;
        assign in_frame = (int'(st_q.win_row) + DR >= 0) && (int'(st_q.win_row) + DR < ROWS) &&
                          (int'(st_q.win_col) + DC >= 0) && (int'(st_q.win_col) + DC < COLS);
        assign win_u[k] = in_frame ? st_q.su[J] : '0;
        assign win_y[k] = in_frame ? st_q.sy[J] : '0;
    end

    assign frame_go  = accept && in_sof;
    assign win_valid = st_q.win_valid;

    // R6
    win_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win_valid |-> (st_q.win_row < ROW_W'(ROWS)) && (st_q.win_col < COL_W'(COLS)));

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(TOTAL)) && !(in_valid && in_sof)
        |=> !st_q.win_valid && (st_q.cnt == CNT_W'(TOTAL)));
endmodule

// File: rtl/dtcnn_cell_core.sv
module dtcnn_cell_core
    import dtcnn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     win_valid,
    input  tap_vec_t win_u,
    input  tap_vec_t win_y,
    input  tap_vec_t fb_coef,
    input  tap_vec_t ct_coef,
    input  word_t    bias,
    output logic     out_valid,
    output word_t    out_state,
    output word_t    out_y
);
    typedef struct packed {
        logic  valid;
        word_t state;
        word_t y;
    } res_t;

    res_t  st_d, st_q;
    acc_t  acc;
    word_t nstate;

    always_comb begin
        st_d = st_q;
        acc  = acc_t'(bias) <<< FW;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + acc_t'($signed(fb_coef[k])) * acc_t'($signed(win_y[k]))
                      + acc_t'($signed(ct_coef[k])) * acc_t'($signed(win_u[k]));
        end
        nstate     = sat_acc(acc >>> FW);
        st_d.valid = win_valid;
        if (win_valid) begin
            st_d.state = nstate;
            st_d.y     = clamp_unit(nstate);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_state = st_q.state;
    assign out_y     = st_q.y;

    // R2
    y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.y <= word_t'(ONE)) && (st_q.y >= -word_t'(ONE)));

    // R2
    y_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && (st_q.state < word_t'(ONE)) && (st_q.state > -word_t'(ONE))
        |-> st_q.y == st_q.state);
endmodule

// File: rtl/dtcnn_stream.sv
module dtcnn_stream
    import dtcnn_pkg::*;
#(
    parameter int COLS = 32,
    parameter int ROWS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [DW-1:0]     in_u,
    input  logic [DW-1:0]     in_x,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic              out_valid,
    output logic [DW-1:0]     out_state,
    output logic [DW-1:0]     out_y
);
    logic     frame_go, win_valid;
    tap_vec_t win_u, win_y, fb_coef, ct_coef;
    word_t    bias, res_state, res_y;

    dtcnn_coef_bank coef_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(word_t'(cfg_wdata)), .swap(frame_go),
        .fb_coef(fb_coef), .ct_coef(ct_coef), .bias(bias)
    );

    dtcnn_window #(.COLS(COLS), .ROWS(ROWS)) win_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_u(word_t'(in_u)), .in_x(word_t'(in_x)), .frame_go(frame_go),
        .win_valid(win_valid), .win_u(win_u), .win_y(win_y)
    );

    dtcnn_cell_core core_i (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_u(win_u), .win_y(win_y),
        .fb_coef(fb_coef), .ct_coef(ct_coef), .bias(bias),
        .out_valid(out_valid), .out_state(res_state), .out_y(res_y)
    );

    assign out_state = res_state;
    assign out_y     = res_y;
endmodule

// File: tb/dtcnn_stream_tb_top.sv
module dtcnn_stream_tb_top;
    localparam int W = 5;
    localparam int H = 4;
    localparam int N = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid, in_sof, cfg_we, out_valid;
    logic signed [15:0] in_u, in_x, cfg_wdata, out_state, out_y;
    logic [4:0] cfg_addr;

    always #10 clk = ~clk;

    dtcnn_stream #(.COLS(W), .ROWS(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_u(in_u), .in_x(in_x), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_state(out_state), .out_y(out_y)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0, seed = 7;
    int sh_a[9], sh_b[9], sh_bias, ac_a[9], ac_b[9], ac_bias;
    int want_a[9], want_b[9], want_bias;
    int u_img[N], x_img[N], exp_s[N], exp_y[N];
    int out_idx = 0, first_out_cyc = 0, sof_cyc = 0;
    string tag = "none";
    bit finished = 1'b0;

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int clampy(int v);
        if (v > 4096) return 4096;
        if (v < -4096) return -4096;
        return v;
    endfunction

    function automatic int rnd(int lo, int hi);
        seed = seed * 1103515245 + 12345;
        return lo + (((seed >>> 8) & 32'h7fffff) % (hi - lo + 1));
    endfunction

    function automatic void model();
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                longint acc = longint'(ac_bias) * 4096;
                for (int k = 0; k < 9; k++) begin
                    int rr = r + k / 3 - 1;
                    int cc = c + k % 3 - 1;
                    if (rr >= 0 && rr < H && cc >= 0 && cc < W)
                        acc += longint'(ac_a[k]) * clampy(x_img[rr * W + cc])
                             + longint'(ac_b[k]) * u_img[rr * W + cc];
                end
                exp_s[r * W + c] = sat16(acc >>> 12);
                exp_y[r * W + c] = clampy(exp_s[r * W + c]);
            end
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_idx == 0) first_out_cyc = cyc;
            if (out_idx < N) begin
                check({tag, " state"}, int'(out_state), exp_s[out_idx]);
                check({tag, " output"}, int'(out_y), exp_y[out_idx]);
            end else begin
                check("R6 no extra result", out_idx, N - 1);
            end
            out_idx++;
        end
    end

    task automatic wr(int addr, int val);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 9) sh_a[addr] = val;
        else if (addr < 18) sh_b[addr - 9] = val;
        else sh_bias = val;
    endtask

    task automatic push_coefs();
        for (int k = 0; k < 9; k++) wr(k, want_a[k]);
        for (int k = 0; k < 9; k++) wr(9 + k, want_b[k]);
        wr(18, want_bias);
    endtask

    task automatic clear_want();
        for (int k = 0; k < 9; k++) begin want_a[k] = 0; want_b[k] = 0; end
        want_bias = 0;
    endtask

    task automatic fill_rand(int lo, int hi);
        for (int p = 0; p < N; p++) begin u_img[p] = rnd(lo, hi); x_img[p] = rnd(lo, hi); end
    endtask

    task automatic run_frame(string t, bit junk, int mid_addr, int mid_val);
        for (int k = 0; k < 9; k++) begin ac_a[k] = sh_a[k]; ac_b[k] = sh_b[k]; end
        ac_bias = sh_bias;
        model();
        tag = t;
        out_idx = 0;
        for (int p = 0; p < N; p++) begin
            in_valid = 1'b1; in_sof = (p == 0);
            in_u = 16'(u_img[p]); in_x = 16'(x_img[p]);
            if (p == 0) sof_cyc = cyc;
            if (p == N / 2 && mid_addr >= 0) begin
                cfg_we = 1'b1; cfg_addr = 5'(mid_addr); cfg_wdata = 16'(mid_val);
                if (mid_addr < 9) sh_a[mid_addr] = mid_val;
                else if (mid_addr < 18) sh_b[mid_addr - 9] = mid_val;
                else sh_bias = mid_val;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; in_sof = 1'b0; in_valid = junk;
        in_u = junk ? 16'sd30000 : 16'sd0; in_x = in_u;
        repeat (W + 4) @(negedge clk);
        in_valid = 1'b0;
        if (junk) check("R7 trailing pixels dropped, result count", out_idx, N);
        else check("R6 result count", out_idx, N);
        check("R6 latency", first_out_cyc - sof_cyc, W + 3);
    endtask

    initial begin
        in_valid = 1'b0; in_sof = 1'b0; in_u = '0; in_x = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int k = 0; k < 9; k++) begin sh_a[k] = 0; sh_b[k] = 0; end
        sh_bias = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset out_valid", int'(out_valid), 0);
        check("R8 reset out_state", int'(out_state), 0);
        check("R8 reset out_y", int'(out_y), 0);

        // R7: stray pixels before any frame start
        tag = "R7 idle";
        out_idx = 0;
        for (int p = 0; p < 8; p++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_u = 16'(1000 * p); in_x = 16'(-700 * p);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (W + 4) @(negedge clk);
        check("R7 idle pixels dropped", out_idx, 0);

        // R8: coefficient banks are zero after reset
        fill_rand(-8192, 8192);
        run_frame("R8 zero coefficients after reset", 1'b0, -1, 0);

        // R3 R4: each control tap alone
        for (int k = 0; k < 9; k++) begin
            clear_want(); want_b[k] = 4096; push_coefs();
            fill_rand(-8000, 8000);
            run_frame("R3/R4 control tap sweep", 1'b0, -1, 0);
        end
        // R2 R3 R4: each feedback tap alone, initial states beyond unit range
        for (int k = 0; k < 9; k++) begin
            clear_want(); want_a[k] = 4096; push_coefs();
            fill_rand(-9000, 9000);
            run_frame("R2/R3/R4 feedback tap sweep", 1'b0, -1, 0);
        end

        // R1: mixed templates and bias
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < 9; k++) begin want_a[k] = rnd(-2048, 2048); want_b[k] = rnd(-2048, 2048); end
            want_bias = rnd(-4096, 4096);
            push_coefs();
            fill_rand(-6144, 6144);
            run_frame("R1 mixed templates", t == 3, -1, 0);
        end

        // R1: saturation both ways
        clear_want();
        for (int k = 0; k < 9; k++) want_b[k] = 32767;
        want_bias = 32767;
        push_coefs();
        for (int p = 0; p < N; p++) begin u_img[p] = 32767; x_img[p] = 0; end
        run_frame("R1 positive saturation", 1'b0, -1, 0);
        want_bias = -32768; push_coefs();
        for (int p = 0; p < N; p++) u_img[p] = -32768;
        run_frame("R1 negative saturation", 1'b0, -1, 0);

        // R5: write during a frame takes effect only at the next frame start
        clear_want(); want_b[4] = 2048; want_bias = 100; push_coefs();
        fill_rand(-4000, 4000);
        run_frame("R5 pending write ignored by current frame", 1'b0, 18, 12000);
        fill_rand(-4000, 4000);
        run_frame("R5 pending write applied at next frame", 1'b0, -1, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule